// File: doc/BRIEF.md
# Chained Descriptor Loader for a DMA Channel

This block gives a single DMA channel the ability to run a chain of transfers without software help between them. The channel registers (control, size, source, destination and next-descriptor pointer) can be written directly while the channel is idle. A start pulse then launches the first transfer on an external data mover. The mover is represented here only by a start pulse out and a done pulse back. When the mover reports done, the block looks at the next-descriptor pointer. If the pointer is zero, the chain is over and a terminal-count event is raised. If it is not zero, the block reads an eight-word descriptor from memory through a simple word read port, reloads every channel register from it and starts the mover again.

A descriptor is eight 32-bit words at consecutive word addresses. Word 0 is control, word 1 is the transfer size counted in source-width units, word 2 is the source address low part and word 3 its high part. Word 4 is the destination low part, word 5 the destination high part, word 6 the next pointer low part and word 7 its high part. The high parts only fill address bits above bit 31. When the address width is 32 they are fetched and then dropped. A pointer that is not 8-byte aligned, a read error and an abort request each stop the chain with their own event. Only the end of the whole chain produces terminal count.

Top module: `desc_chain_loader`

## Requirements
- R1: After reset, busy, rd_req, xfer_start and all three event outputs are 0, and every channel register output is 0.
- R2: A cfg_wr pulse while idle loads ch_ctrl, ch_size, ch_src, ch_dst and ch_link from the cfg inputs. The new values are visible the next cycle. A cfg_wr while busy changes nothing.
- R3: A go pulse while idle raises xfer_start for exactly one cycle, starting the cycle after go, and busy goes to 1. A go while busy has no effect.
- R4: When xfer_done arrives and ch_link is zero, ev_tc is 1 for one cycle starting the next cycle, and busy returns to 0.
- R5: When xfer_done arrives and ch_link is non-zero and 8-byte aligned, the block issues exactly eight reads in order at ch_link + 4·k for k = 0..7. Only one read is outstanding at a time, and rd_addr is held with rd_req high until rd_valid.
- R6: In the cycle after the eighth word is accepted, the channel registers hold the new descriptor: ch_ctrl = word 0, ch_size = word 1, ch_src = word 2, ch_dst = word 4 and ch_link = word 6. xfer_start pulses in that same cycle. No ev_tc is raised for an intermediate descriptor.
- R7: With ADDR_W = 32, words 3, 5 and 7 have no effect, so a descriptor whose link low word is zero ends the chain even if word 7 is non-zero. With ADDR_W > 32, they supply address bits ADDR_W-1..32.
- R8: When xfer_done arrives and any of the low ALIGN_BITS bits of ch_link (default 3) is 1, ev_err pulses the next cycle, no read is issued and busy returns to 0.
- R9: A read returned with rd_err during a fetch raises ev_err the next cycle and ends the chain. It leaves every channel register unchanged and produces no xfer_start.
- R10: An abort_req while busy, during a transfer or a fetch, raises ev_abort the next cycle and returns to idle. Any partly fetched descriptor is discarded and the channel registers are left unchanged. Abort wins over a final rd_valid in the same cycle.
- R11: At most one of ev_tc, ev_err and ev_abort is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write channel registers from cfg inputs (idle only) |
| cfg_ctrl | input | 32 | Control value to program |
| cfg_size | input | 32 | Transfer size to program |
| cfg_src | input | ADDR_W | Source address to program |
| cfg_dst | input | ADDR_W | Destination address to program |
| cfg_link | input | ADDR_W | First descriptor pointer to program |
| go | input | 1 | Start the channel (idle only) |
| abort_req | input | 1 | Stop the chain |
| xfer_start | output | 1 | One-cycle start pulse to the data mover |
| xfer_done | input | 1 | Data mover finished the current transfer |
| ch_ctrl | output | 32 | Current control register |
| ch_size | output | 32 | Current size register |
| ch_src | output | ADDR_W | Current source address |
| ch_dst | output | ADDR_W | Current destination address |
| ch_link | output | ADDR_W | Current next-descriptor pointer |
| rd_req | output | 1 | Word read request, held until rd_valid |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read response present |
| rd_err | input | 1 | Response carries an error |
| rd_data | input | 32 | Read data word |
| busy | output | 1 | Channel is transferring or fetching |
| ev_tc | output | 1 | Terminal count: whole chain finished |
| ev_err | output | 1 | Misaligned pointer or read error |
| ev_abort | output | 1 | Chain stopped by abort |

## Verification
The collision that matters here is an abort request landing in the same cycle as the response to the eighth descriptor read. At that moment the block could either commit and restart the mover or honour the abort. The bench watches for the final rd_valid at address link + 28, asserts abort_req in that very cycle, and judges the result in the following cycle. It expects ev_abort set, no xfer_start, and channel registers still equal to the values programmed before the start. A property in the sequencer checks the same priority on every fetch-time abort seen during the random chains.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FETCH = 2'd2
   } dcl_state_t;

   localparam int unsigned DESC_WORDS = 8;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned WORD_BYTES = WORD_W / 8;

   localparam int unsigned W_CTRL   = 0;
   localparam int unsigned W_SIZE   = 1;
   localparam int unsigned W_SRC_LO = 2;
   localparam int unsigned W_SRC_HI = 3;
   localparam int unsigned W_DST_LO = 4;
   localparam int unsigned W_DST_HI = 5;
   localparam int unsigned W_LNK_LO = 6;
   localparam int unsigned W_LNK_HI = 7;
endpackage

// File: rtl/dcl_addr_join.sv
module dcl_addr_join #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [31:0]       lo,
   input  logic [31:0]       hi,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (ADDR_W == 32) begin : g_narrow
         assign addr = ADDR_W'({hi, lo});
      end else begin : g_wide
         assign addr = {hi[ADDR_W-33:0], lo};
      end
   endgenerate
endmodule

// File: rtl/dcl_shadow.sv
module dcl_shadow #(
   parameter int unsigned N_WORDS = 8,
   parameter int unsigned WORD_W  = 32,
   localparam int unsigned IW     = $clog2(N_WORDS)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IW-1:0]                   wr_idx,
   input  logic [WORD_W-1:0]               wr_data,
   output logic [N_WORDS-1:0][WORD_W-1:0]  words
);
   genvar i;
   generate
      for (i = 0; i < N_WORDS - 1; i++) begin : g_word
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_idx == IW'(i))
               q <= wr_data;
         end
         assign words[i] = q;
      end
   endgenerate

   // last word bypasses storage: it is consumed in the cycle it arrives
   assign words[N_WORDS-1] = wr_data;
endmodule

// File: rtl/dcl_ctrl.sv
module dcl_ctrl
   import dcl_pkg::*;
#(
   parameter int unsigned N_WORDS = 8,
   localparam int unsigned IW     = $clog2(N_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            abort_req,
   input  logic            xfer_done,
   input  logic            link_zero,
   input  logic            link_misaligned,
   input  logic            rd_valid,
   input  logic            rd_err,
   output dcl_state_t      state,
   output logic [IW-1:0]   idx,
   output logic            capture,
   output logic            commit,
   output logic            xfer_start,
   output logic            ev_tc,
   output logic            ev_err,
   output logic            ev_abort
);
   localparam logic [IW-1:0] LAST = IW'(N_WORDS - 1);

   always_comb begin
      capture = (state == ST_FETCH) && rd_valid && !rd_err && !abort_req;
      commit  = capture && (idx == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         xfer_start <= 1'b0;
         ev_tc      <= 1'b0;
         ev_err     <= 1'b0;
         ev_abort   <= 1'b0;
      end else begin
         xfer_start <= 1'b0;
         ev_tc      <= 1'b0;
         ev_err     <= 1'b0;
         ev_abort   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state      <= ST_RUN;
                  xfer_start <= 1'b1;
               end
            end
            ST_RUN: begin
               if (abort_req) begin
                  ev_abort <= 1'b1;
                  state    <= ST_IDLE;
               end else if (xfer_done) begin
                  if (link_zero) begin
                     ev_tc <= 1'b1;
                     state <= ST_IDLE;
                  end else if (link_misaligned) begin
                     ev_err <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     idx   <= '0;
                     state <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (abort_req) begin
                  ev_abort <= 1'b1;
                  state    <= ST_IDLE;
               end else if (rd_valid) begin
                  if (rd_err) begin
                     ev_err <= 1'b1;
                     state  <= ST_IDLE;
                  end else if (idx == LAST) begin
                     xfer_start <= 1'b1;
                     state      <= ST_RUN;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_single_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_tc, ev_err, ev_abort}));

   p_tc_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tc |-> ($past(xfer_done) && $past(link_zero)));

   p_abort_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH && abort_req) |=> (ev_abort && !xfer_start));

   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);
endmodule

// File: rtl/desc_chain_loader.sv
module desc_chain_loader
   import dcl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_ctrl,
   input  logic [31:0]       cfg_size,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [ADDR_W-1:0] cfg_link,
   input  logic              go,
   input  logic              abort_req,
   output logic              xfer_start,
   input  logic              xfer_done,
   output logic [31:0]       ch_ctrl,
   output logic [31:0]       ch_size,
   output logic [ADDR_W-1:0] ch_src,
   output logic [ADDR_W-1:0] ch_dst,
   output logic [ADDR_W-1:0] ch_link,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic              rd_err,
   input  logic [31:0]       rd_data,
   output logic              busy,
   output logic              ev_tc,
   output logic              ev_err,
   output logic              ev_abort
);
   localparam int unsigned IW        = $clog2(DESC_WORDS);
   localparam int unsigned BYTE_SHIFT = $clog2(WORD_BYTES);

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr_w
         $error("desc_chain_loader: ADDR_W must lie in 32..64");
      end
      if (ALIGN_BITS < BYTE_SHIFT || ALIGN_BITS > 12) begin : g_bad_align
         $error("desc_chain_loader: ALIGN_BITS out of range");
      end
   endgenerate

   dcl_state_t                          st;
   logic [IW-1:0]                       idx;
   logic                                capture;
   logic                                commit;
   logic [DESC_WORDS-1:0][WORD_W-1:0]   words;
   logic [ADDR_W-1:0]                   nxt_src;
   logic [ADDR_W-1:0]                   nxt_dst;
   logic [ADDR_W-1:0]                   nxt_link;
   logic                                link_zero;
   logic                                link_misaligned;

   assign link_zero       = (ch_link == '0);
   assign link_misaligned = |ch_link[ALIGN_BITS-1:0];

   dcl_ctrl #(.N_WORDS(DESC_WORDS)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .go              (go),
      .abort_req       (abort_req),
      .xfer_done       (xfer_done),
      .link_zero       (link_zero),
      .link_misaligned (link_misaligned),
      .rd_valid        (rd_valid),
      .rd_err          (rd_err),
      .state           (st),
      .idx             (idx),
      .capture         (capture),
      .commit          (commit),
      .xfer_start      (xfer_start),
      .ev_tc           (ev_tc),
      .ev_err          (ev_err),
      .ev_abort        (ev_abort)
   );

   dcl_shadow #(.N_WORDS(DESC_WORDS), .WORD_W(WORD_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (capture),
      .wr_idx  (idx),
      .wr_data (rd_data),
      .words   (words)
   );

   dcl_addr_join #(.ADDR_W(ADDR_W)) u_join_src (
      .lo (words[W_SRC_LO]), .hi (words[W_SRC_HI]), .addr (nxt_src));
   dcl_addr_join #(.ADDR_W(ADDR_W)) u_join_dst (
      .lo (words[W_DST_LO]), .hi (words[W_DST_HI]), .addr (nxt_dst));
   dcl_addr_join #(.ADDR_W(ADDR_W)) u_join_lnk (
      .lo (words[W_LNK_LO]), .hi (words[W_LNK_HI]), .addr (nxt_link));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_ctrl <= '0;
         ch_size <= '0;
         ch_src  <= '0;
         ch_dst  <= '0;
         ch_link <= '0;
      end else if (commit) begin
         ch_ctrl <= words[W_CTRL];
         ch_size <= words[W_SIZE];
         ch_src  <= nxt_src;
         ch_dst  <= nxt_dst;
         ch_link <= nxt_link;
      end else if (cfg_wr && st == ST_IDLE) begin
         ch_ctrl <= cfg_ctrl;
         ch_size <= cfg_size;
         ch_src  <= cfg_src;
         ch_dst  <= cfg_dst;
         ch_link <= cfg_link;
      end
   end

   assign busy    = (st != ST_IDLE);
   assign rd_req  = (st == ST_FETCH);
   assign rd_addr = ch_link + (ADDR_W'(idx) << BYTE_SHIFT);

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && !abort_req) |=> (rd_req && $stable(rd_addr)));

   p_err_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err |-> ($stable(ch_ctrl) && $stable(ch_link) && $stable(ch_src)));

   p_abort_keeps_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort |-> ($stable(ch_ctrl) && $stable(ch_size) && $stable(ch_dst)));

   p_busy_cfg_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr && !rd_valid) |=> $stable(ch_ctrl));
endmodule

// File: tb/desc_chain_loader_test.sv
module desc_chain_loader_test;
   localparam int AW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          cfg_wr;
   logic [31:0]   cfg_ctrl, cfg_size;
   logic [AW-1:0] cfg_src, cfg_dst, cfg_link;
   logic          go, abort_req, xfer_start, xfer_done;
   logic [31:0]   ch_ctrl, ch_size;
   logic [AW-1:0] ch_src, ch_dst, ch_link;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_valid, rd_err;
   logic [31:0]   rd_data;
   logic          busy, ev_tc, ev_err, ev_abort;

   desc_chain_loader #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ctrl(cfg_ctrl),
      .cfg_size(cfg_size), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_link(cfg_link), .go(go), .abort_req(abort_req),
      .xfer_start(xfer_start), .xfer_done(xfer_done), .ch_ctrl(ch_ctrl),
      .ch_size(ch_size), .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_err(rd_err), .rd_data(rd_data), .busy(busy), .ev_tc(ev_tc),
      .ev_err(ev_err), .ev_abort(ev_abort));

   int total = 0;
   int bad = 0;
   bit finished = 0;
   int tc_cnt = 0, err_cnt = 0, abt_cnt = 0, multi_cnt = 0;
   int rd_n = 0;
   int wcnt = 0;
   logic [31:0] rd_log [8];
   logic [31:0] err_addr = '1;
   logic [31:0] mem [0:255];
   logic [31:0] ectrl, esize, esrc, edst, elink;

   // event monitor
   always @(negedge clk) begin
      if (ev_tc) tc_cnt++;
      if (ev_err) err_cnt++;
      if (ev_abort) abt_cnt++;
      if (32'(ev_tc) + 32'(ev_err) + 32'(ev_abort) > 1) multi_cnt++;
   end

   // memory responder: random latency, one beat per request
   always @(negedge clk) begin
      if (rd_valid) begin
         rd_valid = 1'b0;
         rd_err   = 1'b0;
      end else if (rd_req) begin
         if (wcnt == 0) begin
            rd_valid = 1'b1;
            rd_data  = mem[rd_addr[9:2]];
            rd_err   = (rd_addr == err_addr);
            rd_log[rd_n[2:0]] = rd_addr;
            rd_n++;
            wcnt = int'($urandom % 3);
         end else begin
            wcnt--;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic tick;
      @(negedge clk);
      #2;
   endtask

   task automatic chk_regs(input string req);
      chk_eq({req, " ctrl"}, 64'(ch_ctrl), 64'(ectrl));
      chk_eq({req, " size"}, 64'(ch_size), 64'(esize));
      chk_eq({req, " src"},  64'(ch_src),  64'(esrc));
      chk_eq({req, " dst"},  64'(ch_dst),  64'(edst));
      chk_eq({req, " link"}, 64'(ch_link), 64'(elink));
   endtask

   task automatic make_desc(input int base, input logic [31:0] link);
      int w;
      w = base / 4;
      mem[w + 0] = $urandom;
      mem[w + 1] = $urandom;
      mem[w + 2] = $urandom;
      mem[w + 3] = $urandom | 32'h1;
      mem[w + 4] = $urandom;
      mem[w + 5] = $urandom | 32'h1;
      mem[w + 6] = link;
      mem[w + 7] = $urandom | 32'h1;
   endtask

   function automatic logic [31:0] mw(input int base, input int k);
      return mem[base / 4 + k];
   endfunction

   task automatic start_chain(input logic [31:0] link);
      cfg_ctrl = $urandom; cfg_size = $urandom;
      cfg_src  = $urandom; cfg_dst  = $urandom; cfg_link = link;
      cfg_wr = 1'b1;
      tick;
      cfg_wr = 1'b0;
      ectrl = cfg_ctrl; esize = cfg_size; esrc = cfg_src;
      edst = cfg_dst; elink = cfg_link;
      chk_regs("R2 idle cfg load");
      go = 1'b1;
      tick;
      go = 1'b0;
      chk_eq("R3 start pulse", 64'(xfer_start), 64'd1);
      chk_eq("R3 busy", 64'(busy), 64'd1);
   endtask

   task automatic end_xfer;
      int d;
      d = int'($urandom % 3);
      for (int i = 0; i < d; i++) tick;
      xfer_done = 1'b1;
      tick;
      xfer_done = 1'b0;
   endtask

   task automatic hop(input int base);
      int t0, n;
      t0 = tc_cnt;
      rd_n = 0;
      end_xfer;
      n = 0;
      while (!xfer_start && n < 200) begin
         tick;
         n++;
      end
      chk_eq("R6 restart seen", 64'(xfer_start), 64'd1);
      chk_eq("R5 read count", 64'(rd_n), 64'd8);
      for (int k = 0; k < 8; k++)
         chk_eq("R5 read order", 64'(rd_log[k]), 64'(base + 4 * k));
      ectrl = mw(base, 0); esize = mw(base, 1); esrc = mw(base, 2);
      edst = mw(base, 4); elink = mw(base, 6);
      chk_regs("R6 R7 reload");
      chk_eq("R6 no intermediate tc", 64'(tc_cnt), 64'(t0));
   endtask

   task automatic finish_last;
      int t0;
      t0 = tc_cnt;
      end_xfer;
      chk_eq("R4 tc pulse", 64'(ev_tc), 64'd1);
      chk_eq("R4 idle", 64'(busy), 64'd0);
      tick;
      chk_eq("R4 single tc", 64'(tc_cnt - t0), 64'd1);
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
      rst_n = 1'b0; cfg_wr = 1'b0; go = 1'b0; abort_req = 1'b0;
      xfer_done = 1'b0; rd_valid = 1'b0; rd_err = 1'b0; rd_data = '0;
      cfg_ctrl = '0; cfg_size = '0; cfg_src = '0; cfg_dst = '0; cfg_link = '0;
      repeat (3) tick;
      chk_eq("R1 busy", 64'(busy), 64'd0);
      chk_eq("R1 rd_req", 64'(rd_req), 64'd0);
      chk_eq("R1 start", 64'(xfer_start), 64'd0);
      chk_eq("R1 events", 64'({ev_tc, ev_err, ev_abort}), 64'd0);
      ectrl = 0; esize = 0; esrc = 0; edst = 0; elink = 0;
      chk_regs("R1 regs");
      rst_n = 1'b1;
      tick;

      // directed chain of two descriptors; last has zero low link, nonzero high
      make_desc(64, 32'd128);
      make_desc(128, 32'd0);
      start_chain(32'd64);
      // cfg write and go while busy are ignored
      cfg_ctrl = ~ectrl; cfg_link = 32'h300; cfg_wr = 1'b1; go = 1'b1;
      tick;
      cfg_wr = 1'b0; go = 1'b0;
      chk_regs("R2 busy cfg ignored");
      chk_eq("R3 go while busy", 64'(xfer_start), 64'd0);
      hop(64);
      hop(128);
      chk(mw(128, 7) != 0, "R7 high link word nonzero", 64'(mw(128, 7)), 64'd1);
      finish_last;

      // random chains
      for (int it = 0; it < 6; it++) begin
         int nh;
         nh = 1 + int'($urandom % 4);
         for (int j = 0; j < nh; j++)
            make_desc(32 * (1 + it * 5 + j),
                      (j == nh - 1) ? 32'd0 : 32'(32 * (2 + it * 5 + j)));
         start_chain(32'(32 * (1 + it * 5)));
         for (int j = 0; j < nh; j++) hop(32 * (1 + it * 5 + j));
         finish_last;
      end

      // misaligned pointers
      for (int m = 0; m < 2; m++) begin
         start_chain(32'(32 * 30 + ((m == 0) ? 4 : 2)));
         rd_n = 0;
         end_xfer;
         chk_eq("R8 error pulse", 64'(ev_err), 64'd1);
         chk_eq("R8 idle", 64'(busy), 64'd0);
         tick;
         chk_eq("R8 no read", 64'(rd_n), 64'd0);
      end

      // read error mid-fetch
      begin
         int n;
         make_desc(32 * 31, 32'd0);
         err_addr = 32 * 31 + 12;
         start_chain(32'(32 * 31));
         end_xfer;
         n = 0;
         while (!ev_err && n < 200) begin
            chk_eq("R9 no restart", 64'(xfer_start), 64'd0);
            tick;
            n++;
         end
         chk_eq("R9 error pulse", 64'(ev_err), 64'd1);
         chk_eq("R9 idle", 64'(busy), 64'd0);
         chk_regs("R9 regs kept");
         err_addr = '1;
      end

      // abort in the middle of a fetch
      begin
         int n;
         make_desc(64, 32'd0);
         start_chain(32'd64);
         rd_n = 0;
         end_xfer;
         n = 0;
         while (rd_n < 3 && n < 200) begin tick; n++; end
         abort_req = 1'b1;
         tick;
         abort_req = 1'b0;
         chk_eq("R10 abort pulse", 64'(ev_abort), 64'd1);
         chk_eq("R10 idle", 64'(busy), 64'd0);
         chk_regs("R10 regs kept mid fetch");
      end

      // abort in the same cycle as the last descriptor word
      begin
         int n;
         start_chain(32'd64);
         end_xfer;
         n = 0;
         while (!(rd_valid && rd_addr == 32'd92) && n < 200) begin tick; n++; end
         chk_eq("R10 final word seen", 64'(rd_valid), 64'd1);
         abort_req = 1'b1;
         tick;
         abort_req = 1'b0;
         chk_eq("R10 abort beats last word", 64'(ev_abort), 64'd1);
         chk_eq("R10 no restart", 64'(xfer_start), 64'd0);
         chk_regs("R10 regs kept collision");
      end

      // abort while the transfer is running
      start_chain(32'd0);
      abort_req = 1'b1;
      tick;
      abort_req = 1'b0;
      chk_eq("R10 abort in run", 64'(ev_abort), 64'd1);
      chk_eq("R10 run idle", 64'(busy), 64'd0);

      chk_eq("R11 one event per cycle", 64'(multi_cnt), 64'd0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule